// File: doc/BRIEF.md
# Stop-Mode Wake-Up Recovery Controller

This block parks a processor core in a clock-stopped low-power state and brings it back when a chosen external pin condition appears. Software configures it through one byte-wide control register on a simple write/read bus. When the core raises a stop request, the block drops its clock-enable output. From then on it watches one wake source at a programmed polarity. The source is picked by a three-bit code and can be a single pin, the top pin of an 8-bit pin group, or the NOR of the lower half or of the whole group.

When the selected source reaches the programmed level, the block restarts the clocks. It raises a recovery-reset output, either as a single-cycle pulse or held for a parameterised number of cycles before the clock enable returns. It also sets a sticky flag that only power-on reset clears. A further register bit drives a divide-by-16 select for the system and timer clock dividers, which sit outside this block.

The selected wake signal passes through a synchronizer chain before its level is compared, so the pins may be fully asynchronous to the block's free-running clock.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While `por_n` is low, and right after it is released, `clk_en` is 1, `div16_en` is 0, `rec_rst` is 0 and a read of the register returns 8'h00.
- R2: A write with `bus_wr` high and `bus_addr` equal to `REG_ADDR` (default 8'h0B) loads `div16_en` from `bus_wdata[0]`; the new value appears the cycle after the write. Writes to any other address leave `div16_en` unchanged.
- R3: While `bus_addr` equals `REG_ADDR`, `bus_rdata` is `{flag, 7'b0}`. The configuration bits read as 0, and writing `bus_wdata[7]` has no effect on the flag.
- R4: A `stop_req` sampled high while `clk_en` is 1 drives `clk_en` to 0 on the following cycle. `clk_en` then stays 0 until a wake event or power-on reset.
- R5: `bus_wdata[4:2]` selects the wake source: 3'b010 `pin_a`, 3'b011 `pin_b`, 3'b100 `pin_c`, 3'b101 `grp_pins[7]`, 3'b110 NOR of `grp_pins[3:0]`, 3'b111 NOR of `grp_pins[7:0]`. `bus_wdata[6]` sets the required level (1 high, 0 low) and is applied after the NOR is formed. Pins that are not selected have no effect.
- R6: With source code 3'b000 or 3'b001, no pin activity ends the stopped state; only `por_n` does.
- R7: The wake level passes through a two-stage synchronizer. A selected source that becomes active ahead of clock edge k leaves `clk_en` low after edges k and k+1. With the delay off, `clk_en` is high after edge k+2.
- R8: With `bus_wdata[5]` = 0, `rec_rst` is high for exactly one cycle, the first cycle in which `clk_en` is back at 1.
- R9: With `bus_wdata[5]` = 1, `rec_rst` is high for `DELAY_CYC` cycles while `clk_en` stays 0. `clk_en` rises in the cycle `rec_rst` falls.
- R10: A wake event sets the flag (register bit 7) to 1. It stays 1 across further writes and stops, and only `por_n` clears it. A recovery leaves `div16_en` and the other settings unchanged.
- R11: While the clocks run (`clk_en` = 1), pin activity never changes `clk_en` and never raises `rec_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that keeps running while stopped |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, flag in bit 7 |
| stop_req | input | 1 | Core request to enter the stopped state |
| pin_a | input | 1 | Wake pin A (code 3'b010) |
| pin_b | input | 1 | Wake pin B (code 3'b011) |
| pin_c | input | 1 | Wake pin C (code 3'b100) |
| grp_pins | input | GRP_W | Pin group; top bit and NOR combinations are wake sources |
| clk_en | output | 1 | Clock enable for the core clocks |
| div16_en | output | 1 | Divide-by-16 select for system and timer clocks |
| rec_rst | output | 1 | Recovery-reset output |

## Verification
The assertions assume that `stop_req` is only meaningful while the clocks run and that the wake-source code is not moved to a live source in the same cycle it is checked. They also assume `por_n` is the only way out of a stop when the code is 3'b000 or 3'b001. The stimulus writes the configuration and drives the pins to their inactive pattern several cycles before each stop request, so the synchronizer holds an idle value when the stop begins. It then drives decoy patterns on the unselected pins before activating the chosen source. The register is rewritten while stopped only with codes that cannot wake.

// File: rtl/swr_pkg.sv
package swr_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned BIT_FLAG  = 7;
   localparam int unsigned BIT_LEVEL = 6;
   localparam int unsigned BIT_DELAY = 5;
   localparam int unsigned SRC_MSB   = 4;
   localparam int unsigned SRC_LSB   = 2;
   localparam int unsigned BIT_DIV   = 0;

   typedef enum logic [2:0] {
      SRC_POR_ONLY = 3'b000,
      SRC_RSVD     = 3'b001,
      SRC_PIN_A    = 3'b010,
      SRC_PIN_B    = 3'b011,
      SRC_PIN_C    = 3'b100,
      SRC_GRP_TOP  = 3'b101,
      SRC_NOR_LO   = 3'b110,
      SRC_NOR_ALL  = 3'b111
   } wake_src_e;

   typedef struct packed {
      logic      level;
      logic      delay_en;
      wake_src_e src;
      logic      div16;
   } swr_cfg_t;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_HOLD = 2'd2
   } swr_state_e;
endpackage

// File: rtl/swr_cfg_reg.sv
module swr_cfg_reg
   import swr_pkg::*;
#(
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h0B
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   input  logic               set_flag,
   output swr_cfg_t           cfg,
   output logic               flag,
   output logic [REG_W-1:0]   bus_rdata
);
   logic hit_addr;
   logic unused_wbits;

   assign hit_addr     = (bus_addr == REG_ADDR);
   assign unused_wbits = ^{bus_wdata[BIT_FLAG], bus_wdata[1]};

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg <= '0;
      end else if (bus_wr && hit_addr) begin
         cfg.level    <= bus_wdata[BIT_LEVEL];
         cfg.delay_en <= bus_wdata[BIT_DELAY];
         cfg.src      <= wake_src_e'(bus_wdata[SRC_MSB:SRC_LSB]);
         cfg.div16    <= bus_wdata[BIT_DIV];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) flag <= 1'b0;
      else if (set_flag) flag <= 1'b1;
   end

   assign bus_rdata = hit_addr ? {flag, {(REG_W-1){1'b0}}} : '0;

   assert_flag_sticky_R10 : assert property (@(posedge clk) disable iff (!por_n)
      flag |=> flag);

   assert_div_write_R2 : assert property (@(posedge clk) disable iff (!por_n)
      (bus_wr && hit_addr) |=> (cfg.div16 == $past(bus_wdata[BIT_DIV])));
endmodule

// File: rtl/swr_wake_sel.sv
module swr_wake_sel
   import swr_pkg::*;
#(
   parameter int unsigned GRP_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  wake_src_e        src,
   input  logic             level,
   input  logic             pin_a,
   input  logic             pin_b,
   input  logic             pin_c,
   input  logic [GRP_W-1:0] grp_pins,
   output logic             wake_hit
);
   localparam int unsigned HALF_W = GRP_W / 2;

   logic                   raw_sel;
   logic                   src_live;
   logic                   nor_lo;
   logic                   nor_all;
   logic [SYNC_STAGES-1:0] sync_q;

   assign nor_lo  = ~|grp_pins[HALF_W-1:0];
   assign nor_all = ~|grp_pins;

   always_comb begin
      raw_sel  = 1'b0;
      src_live = 1'b1;
      unique case (src)
         SRC_PIN_A:   raw_sel = pin_a;
         SRC_PIN_B:   raw_sel = pin_b;
         SRC_PIN_C:   raw_sel = pin_c;
         SRC_GRP_TOP: raw_sel = grp_pins[GRP_W-1];
         SRC_NOR_LO:  raw_sel = nor_lo;
         SRC_NOR_ALL: raw_sel = nor_all;
         default:     src_live = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_sel};
   end

   assign wake_hit = src_live && (sync_q[SYNC_STAGES-1] == level);
endmodule

// File: rtl/swr_fsm.sv
module swr_fsm
   import swr_pkg::*;
#(
   parameter int unsigned DELAY_CYC = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic stop_req,
   input  logic wake_hit,
   input  logic delay_en,
   output logic clk_en,
   output logic rec_rst,
   output logic wake_evt
);
   localparam int unsigned    CNT_W    = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYC - 1);

   swr_state_e       state;
   logic [CNT_W-1:0] cnt;

   assign wake_evt = (state == ST_STOP) && wake_hit;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state   <= ST_RUN;
         clk_en  <= 1'b1;
         rec_rst <= 1'b0;
         cnt     <= '0;
      end else begin
         unique case (state)
            ST_RUN: begin
               rec_rst <= 1'b0;
               if (stop_req) begin
                  state  <= ST_STOP;
                  clk_en <= 1'b0;
               end
            end
            ST_STOP: begin
               if (wake_hit) begin
                  rec_rst <= 1'b1;
                  if (delay_en) begin
                     state <= ST_HOLD;
                     cnt   <= CNT_LOAD;
                  end else begin
                     state  <= ST_RUN;
                     clk_en <= 1'b1;
                  end
               end
            end
            ST_HOLD: begin
               if (cnt == '0) begin
                  state   <= ST_RUN;
                  clk_en  <= 1'b1;
                  rec_rst <= 1'b0;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   assert_stop_gates_R4 : assert property (@(posedge clk) disable iff (!por_n)
      (clk_en && stop_req) |=> !clk_en);

   assert_single_pulse_R8 : assert property (@(posedge clk) disable iff (!por_n)
      (clk_en && rec_rst) |=> !rec_rst);

   assert_hold_exit_R9 : assert property (@(posedge clk) disable iff (!por_n)
      (rec_rst && !clk_en) |=> (rec_rst || clk_en));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
   import swr_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h0B,
   parameter int unsigned       GRP_W       = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       DELAY_CYC   = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              stop_req,
   input  logic              pin_a,
   input  logic              pin_b,
   input  logic              pin_c,
   input  logic [GRP_W-1:0]  grp_pins,
   output logic              clk_en,
   output logic              div16_en,
   output logic              rec_rst
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("DELAY_CYC must be at least 1");
      end
      if ((GRP_W < 2) || (GRP_W % 2 != 0)) begin : g_bad_grp
         $error("GRP_W must be even and at least 2");
      end
   endgenerate

   swr_cfg_t cfg;
   logic     flag;
   logic     wake_hit;
   logic     wake_evt;

   swr_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
      .clk       (clk),
      .por_n     (por_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .set_flag  (wake_evt),
      .cfg       (cfg),
      .flag      (flag),
      .bus_rdata (bus_rdata)
   );

   swr_wake_sel #(.GRP_W(GRP_W), .SYNC_STAGES(SYNC_STAGES)) u_sel (
      .clk      (clk),
      .por_n    (por_n),
      .src      (cfg.src),
      .level    (cfg.level),
      .pin_a    (pin_a),
      .pin_b    (pin_b),
      .pin_c    (pin_c),
      .grp_pins (grp_pins),
      .wake_hit (wake_hit)
   );

   swr_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
      .clk      (clk),
      .por_n    (por_n),
      .stop_req (stop_req),
      .wake_hit (wake_hit),
      .delay_en (cfg.delay_en),
      .clk_en   (clk_en),
      .rec_rst  (rec_rst),
      .wake_evt (wake_evt)
   );

   assign div16_en = cfg.div16;

   assert_no_pin_exit_R6 : assert property (@(posedge clk) disable iff (!por_n)
      (!clk_en && !rec_rst && ((cfg.src == SRC_POR_ONLY) || (cfg.src == SRC_RSVD)))
      |=> !clk_en);

   assert_flag_on_wake_R10 : assert property (@(posedge clk) disable iff (!por_n)
      $rose(rec_rst) |-> flag);
endmodule

// File: tb/tb_stop_wake_ctrl.sv
module tb_stop_wake_ctrl;
   localparam int          DLY  = 5;
   localparam logic [7:0]  RADR = 8'h0B;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic [7:0] bus_addr = RADR;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       stop_req = 1'b0;
   logic       pin_a = 1'b0, pin_b = 1'b0, pin_c = 1'b0;
   logic [7:0] grp_pins = 8'h00;
   logic       clk_en, div16_en, rec_rst;

   int checks = 0;
   int fails  = 0;
   int run_len = 0;
   bit done = 1'b0;
   int exp_q[$];

   always #4 clk = ~clk;

   stop_wake_ctrl #(.REG_ADDR(RADR), .DELAY_CYC(DLY)) dut (
      .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_req(stop_req),
      .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .grp_pins(grp_pins),
      .clk_en(clk_en), .div16_en(div16_en), .rec_rst(rec_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_pins(input logic [10:0] v);
      {grp_pins, pin_c, pin_b, pin_a} = v;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = RADR;
   endtask

   // monitor: measures each rec_rst run and compares with the scoreboard
   always @(negedge clk) begin
      if (por_n) begin
         if (rec_rst) run_len++;
         else if (run_len > 0) begin
            if (exp_q.size() == 0) chk("R8 unexpected recovery", 32'(run_len), 32'd0);
            else chk("R8/R9 scoreboard pulse length", 32'(run_len), 32'(exp_q.pop_front()));
            run_len = 0;
         end
      end
   end

   task automatic run_wake(input logic [7:0] cfg, input logic [10:0] idle,
                           input logic [10:0] decoy, input logic [10:0] wake,
                           input string rq);
      bit dly;
      dly = cfg[5];
      wr(RADR, cfg);
      set_pins(idle);
      repeat (4) @(negedge clk);
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      chk("R4 clk_en low after stop", 32'(clk_en), 32'd0);
      set_pins(decoy);
      repeat (5) @(negedge clk);
      chk({rq, " unselected pins ignored"}, 32'({clk_en, rec_rst}), 32'd0);
      set_pins(wake);
      exp_q.push_back(dly ? DLY : 1);
      repeat (2) @(negedge clk);
      chk("R7 no early wake", 32'(clk_en), 32'd0);
      @(negedge clk);
      chk("R7 rec_rst on wake", 32'(rec_rst), 32'd1);
      chk({rq, " clk_en after sync"}, 32'(clk_en), dly ? 32'd0 : 32'd1);
      if (dly) begin
         repeat (DLY - 1) @(negedge clk);
         chk("R9 last hold cycle", 32'({clk_en, rec_rst}), 32'b01);
         @(negedge clk);
         chk("R9 release", 32'({clk_en, rec_rst}), 32'b10);
      end else begin
         @(negedge clk);
         chk("R8 pulse ended", 32'({clk_en, rec_rst}), 32'b10);
      end
      set_pins(idle);
      chk("R10 flag set", 32'(bus_rdata), 32'h80);
      chk("R10 div16 kept", 32'(div16_en), 32'(cfg[0]));
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", 32'({clk_en, div16_en, rec_rst}), 32'b100);
      chk("R1 reset readback", 32'(bus_rdata), 32'h00);
      por_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({clk_en, div16_en, rec_rst}), 32'b100);

      wr(RADR, 8'h01);
      chk("R2 div16 write", 32'(div16_en), 32'd1);
      wr(8'h0C, 8'h00);
      chk("R2 other address ignored", 32'(div16_en), 32'd1);
      chk("R3 config bits read 0", 32'(bus_rdata), 32'h00);
      wr(RADR, 8'h81);
      chk("R3 flag not writable", 32'(bus_rdata), 32'h00);

      // R11: running, pins active for several sources
      wr(RADR, 8'h49);
      for (int i = 0; i < 6; i++) begin
         set_pins((i % 2 == 0) ? 11'h7FF : 11'h000);
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk("R11 running unaffected", 32'({clk_en, rec_rst}), 32'b10);

      // R5 source and polarity cases
      run_wake(8'h49, 11'h000, 11'h7FE, 11'h001, "R5 pin_a high");
      run_wake(8'h2C, 11'h7FF, 11'h002, 11'h000, "R5 pin_b low delayed");
      run_wake(8'h50, 11'h000, 11'h7FB, 11'h004, "R5 pin_c high");
      run_wake(8'h75, 11'h000, 11'h3FF, 11'h400, "R5 group top high delayed");
      run_wake(8'h58, 11'h008, 11'h7FF, 11'h787, "R5 NOR low half high");
      run_wake(8'h1C, 11'h007, 11'h000, 11'h107, "R5 NOR all low");

      // R6: codes 000 and 001 never wake from pins
      wr(RADR, 8'h00);
      set_pins(11'h000);
      repeat (4) @(negedge clk);
      stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
      for (int i = 0; i < 10; i++) begin
         set_pins((i % 2 == 0) ? 11'h7FF : 11'h000);
         @(negedge clk);
      end
      chk("R6 code 000 stays stopped", 32'({clk_en, rec_rst}), 32'b00);
      wr(RADR, 8'h44);
      for (int i = 0; i < 10; i++) begin
         set_pins((i % 2 == 0) ? 11'h000 : 11'h7FF);
         @(negedge clk);
      end
      chk("R6 code 001 stays stopped", 32'({clk_en, rec_rst}), 32'b00);
      chk("R10 flag still set", 32'(bus_rdata), 32'h80);

      por_n = 1'b0;
      #1;
      chk("R1 power-on exit", 32'({clk_en, div16_en, rec_rst}), 32'b100);
      chk("R10 flag cleared by por", 32'(bus_rdata), 32'h00);
      @(negedge clk);
      por_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R4 run did not complete actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule